// File: doc/BRIEF.md
# Daisy-Chained Distributed Bus Arbiter

This block models a group of bus agents that share one bus without a central arbiter. The agents sit in a fixed line ordered by priority. Each agent has a grant-enable input from the agent above it and a grant-enable output to the agent below it. An agent that wants the bus blocks the enable for everything below it. The single agent that sees the enable open while it is requesting holds priority.

The agent holding priority takes the bus at a clock edge only if the shared BUSY line is low at that edge. It then drives BUSY, and keeps the bus until its own done input is pulsed. BUSY is the OR of every agent's drive. An agent that owns the bus is never preempted, even by an agent above it in the line.

The enable ripple is combinational, so the full chain must settle within one clock period. Requests and done are level inputs sampled on the rising clock edge. Reset is synchronous and active high.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: While reset is high, and at the first edge after it, no agent owns the bus and BUSY is low.
- R2: Bit i of `prio_out_o` is high exactly when none of the agents with index 0 to i has its `req_i` bit high. Index 0 is the highest priority, and its enable input is always open.
- R3: If BUSY is low at a rising edge and some `req_i` bits are high, the requester with the lowest index owns the bus after that edge, and its `grant_o` bit goes high.
- R4: At most one bit of `grant_o` is ever high.
- R5: An owner keeps its grant while its own `done_i` bit is low, whatever any request does, including requests from agents with a lower index.
- R6: A high `done_i` bit on the owning agent clears its grant and BUSY at the next edge.
- R7: A `done_i` bit on an agent that does not own the bus has no effect on the grant or on BUSY.
- R8: `bus_busy_o` is high exactly when some bit of `grant_o` is high.
- R9: A grant is only taken at an edge where BUSY was low. After a release there is therefore one cycle with no owner before a waiting agent takes the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_AGENTS | Request level per agent; bit 0 has the highest priority |
| done_i | input | N_AGENTS | Release pulse per agent |
| grant_o | output | N_AGENTS | Per-agent bus ownership flag |
| bus_busy_o | output | 1 | Shared BUSY line, the OR of all agent drives |
| prio_out_o | output | N_AGENTS | Enable output of each agent in the chain |

## Verification
On every cycle, the assertions check the following:
- at most one agent drives BUSY;
- BUSY agrees with the grants;
- each agent's enable output follows its enable input and its request;
- an owner keeps or drops the bus exactly as its done input says;
- a new grant appears only after an edge with BUSY low.

Only the bench's scenarios can show which agent wins, because that depends on comparing the whole request pattern with the priority order. The same holds for the one idle cycle between a release and the next take-over, and for the fact that a done pulse on a non-owner leaves the bus untouched. These scenarios include a sweep of every request pattern on an idle bus and a long pseudo-random run checked against an arithmetic model.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      AG_IDLE = 1'b0,
      AG_OWN  = 1'b1
   } agent_state_e;
endpackage

// File: rtl/arb_chain_agent.sv
module arb_chain_agent
   import arb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic prio_in,
   input  logic req,
   input  logic done,
   input  logic bus_busy,
   output logic prio_out,
   output logic busy_drv,
   output logic owns
);
   agent_state_e state_q;

   // A requesting agent blocks every agent below it.
   assign prio_out = prio_in & ~req;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= AG_IDLE;
      end else begin
         case (state_q)
            AG_IDLE: if (prio_in && req && !bus_busy) state_q <= AG_OWN;
            AG_OWN:  if (done) state_q <= AG_IDLE;
            default: state_q <= AG_IDLE;
         endcase
      end
   end

   assign owns     = (state_q == AG_OWN);
   assign busy_drv = owns;

   // R5
   keep_owner_chk: assert property (@(posedge clk) disable iff (rst)
      (owns && !done) |=> owns);

   // R6
   release_chk: assert property (@(posedge clk) disable iff (rst)
      (owns && done) |=> !owns);

   // R9
   seize_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(owns) |-> $past(!bus_busy && prio_in && req));

   // R2
   chain_pass_chk: assert property (@(posedge clk) disable iff (rst)
      prio_out == (prio_in && !req));
endmodule

// File: rtl/arb_busy_or.sv
module arb_busy_or #(
   parameter int N_AGENTS = 4
) (
   input  logic [N_AGENTS-1:0] drv,
   output logic                busy
);
   generate
      if (N_AGENTS == 1) begin : g_single
         assign busy = drv[0];
      end else begin : g_multi
         assign busy = |drv;
      end
   endgenerate
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter #(
   parameter int N_AGENTS = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_AGENTS-1:0] req_i,
   input  logic [N_AGENTS-1:0] done_i,
   output logic [N_AGENTS-1:0] grant_o,
   output logic                bus_busy_o,
   output logic [N_AGENTS-1:0] prio_out_o
);
   localparam int CHAIN_W = N_AGENTS + 1;

   generate
      if (N_AGENTS < 1 || N_AGENTS > 64) begin : g_bad_cfg
         $error("daisy_bus_arbiter: N_AGENTS must be 1..64");
      end
   endgenerate

   logic [CHAIN_W-1:0]  chain;
   logic [N_AGENTS-1:0] drv;
   logic                busy_line;

   // The head of the chain always sees the enable open.
   assign chain[0] = 1'b1;

   generate
      for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
         arb_chain_agent u_ag (
            .clk      (clk),
            .rst      (rst),
            .prio_in  (chain[i]),
            .req      (req_i[i]),
            .done     (done_i[i]),
            .bus_busy (busy_line),
            .prio_out (chain[i+1]),
            .busy_drv (drv[i]),
            .owns     (grant_o[i])
         );
      end
   endgenerate

   arb_busy_or #(.N_AGENTS(N_AGENTS)) u_or (
      .drv  (drv),
      .busy (busy_line)
   );

   assign bus_busy_o = busy_line;
   assign prio_out_o = chain[CHAIN_W-1:1];

   // R4
   single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_o));

   // R8
   busy_match_chk: assert property (@(posedge clk) disable iff (rst)
      bus_busy_o == (grant_o != '0));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $past(rst) |-> (grant_o == '0 && !bus_busy_o));
endmodule

// File: tb/sim_daisy_bus_arbiter.sv
`timescale 1ns/1ps
module sim_daisy_bus_arbiter;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] req_i = '0;
   logic [N-1:0] done_i = '0;
   logic [N-1:0] grant_o;
   logic         bus_busy_o;
   logic [N-1:0] prio_out_o;

   int nchk = 0;
   int nerr = 0;
   int own  = -1;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   daisy_bus_arbiter #(.N_AGENTS(N)) u0 (
      .clk(clk), .rst(rst), .req_i(req_i), .done_i(done_i),
      .grant_o(grant_o), .bus_busy_o(bus_busy_o), .prio_out_o(prio_out_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [N-1:0] r);
      for (int i = N - 1; i >= 0; i--) if (r[i]) lowest = i;
      if (r == '0) lowest = -1;
   endfunction

   function automatic logic [N-1:0] exp_prio(input logic [N-1:0] r);
      logic open = 1'b1;
      for (int i = 0; i < N; i++) begin
         open = open & ~r[i];
         exp_prio[i] = open;
      end
   endfunction

   // Called at a falling edge: drive inputs, check the chain, advance the model,
   // then check the registered outputs at the next falling edge.
   task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
      logic [N-1:0] eg;
      req_i  = r;
      done_i = d;
      #1;
      check(prio_out_o == exp_prio(r), "R2 chain", prio_out_o, exp_prio(r));
      if (own >= 0) begin
         if (d[own]) own = -1;
      end else if (r != '0) begin
         own = lowest(r);
      end
      @(negedge clk);
      eg = (own >= 0) ? (N'(1) << own) : '0;
      check(grant_o == eg, "R3 R5 R6 R7 R9 grant", grant_o, eg);
      check($countones(grant_o) <= 1, "R4 onehot", grant_o, 0);
      check(bus_busy_o == (own >= 0), "R8 busy", bus_busy_o, own >= 0);
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(grant_o == '0 && !bus_busy_o, "R1 reset", {bus_busy_o, grant_o}, 0);
      rst = 1'b0;

      // R3: every request pattern on an idle bus, then release by the owner (R6)
      for (int p = 1; p < (1 << N); p++) begin
         step(N'(p), '0);
         step(N'(p), N'(1) << lowest(N'(p)));
         step('0, '0);
      end

      // R5: agent 2 owns; a higher-priority request must not preempt it
      step(4'b0100, '0);
      step(4'b0001, '0);
      step(4'b0011, '0);
      // R7: done on non-owners is ignored
      step(4'b0001, 4'b1011);
      check(grant_o == 4'b0100, "R7 ignore", grant_o, 4'b0100);
      // R9: release, idle cycle, then agent 0 takes over
      step(4'b0001, 4'b0100);
      check(grant_o == '0, "R9 gap", grant_o, 0);
      step(4'b0001, '0);
      check(grant_o == 4'b0001, "R9 takeover", grant_o, 4'b0001);
      step('0, 4'b0001);

      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[3:0], lfsr[7:4] & lfsr[11:8]);
      end

      rst = 1'b1;
      @(negedge clk);
      check(grant_o == '0 && !bus_busy_o, "R1 reset again", {bus_busy_o, grant_o}, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule